// File: doc/BRIEF.md
# Linear sensor pixel sequencer

This block is the digital sequencer of a linear photodiode array. A single serial start pulse, sampled on a rising clock edge while the block is idle, opens a frame. The start token then walks down a chain of select stages, one pixel per clock, so that the pixel sampling capacitors are read out in order onto a shared analog bus.

The same token sets the timing of the other frame controls. A global hold strobe fires once, at the start of the frame, to freeze every pixel's sample at the same moment. An integrator reset covers a fixed number of opening clocks, and the next integration period then begins. The output enable for the analog driver stays high for as long as a pixel is selected. It is released on the clock after the last pixel, which returns the block to idle.

A start pulse that arrives while a frame is running has no effect on the sequence. It sets a sticky protocol-error flag, which only a synchronous reset clears. The block also reports the number of the selected pixel in binary, with a valid flag.

Top module: `linsens_seq`

## Requirements
- R1: While and directly after synchronous reset, no pixel is selected, and the hold, integrator-reset, output-enable, valid and error outputs are all low. The index bus is 0.
- R2: When si_i is high at a rising edge while the block is idle, pix_sel_o is 1 after that edge. Bit 0 is pixel 1.
- R3: After the k-th rising edge of a frame (edge 1 is the accepting edge), exactly pix_sel_o bit k-1 is set, for k = 1 to NUM_PIX. pix_idx_o equals k-1, which is the pixel number minus one.
- R4: hold_o is high for exactly one cycle, after the accepting edge. At all other times it is low.
- R5: int_rst_o is high after edges 1 to RST_CLKS (default 18) of a frame. It is low from edge RST_CLKS+1 (default 19) onward.
- R6: out_en_o is high after edges 1 to NUM_PIX. After edge NUM_PIX+1 (default 129), out_en_o is low and pix_sel_o is all zero.
- R7: A start pulse sampled at edge NUM_PIX+2 (default 130) of a frame is accepted and begins a new frame.
- R8: si_i sampled high at edges 2 to NUM_PIX+1 of a frame does not change the sequence (R3 to R6 still hold), and it sets proto_err_o after that edge.
- R9: proto_err_o, once set, stays high until synchronous reset, which clears it.
- R10: pix_vld_o is high exactly when a pixel is selected. When it is low, pix_idx_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| si_i | input | 1 | Serial start pulse |
| pix_sel_o | output | NUM_PIX | One-hot pixel select, bit 0 = pixel 1 |
| pix_idx_o | output | $clog2(NUM_PIX) | Selected pixel number minus one |
| pix_vld_o | output | 1 | A pixel is selected |
| hold_o | output | 1 | Global sample-hold strobe |
| int_rst_o | output | 1 | Integrator reset window |
| out_en_o | output | 1 | Analog output drive enable |
| proto_err_o | output | 1 | Sticky error: start seen during a frame |

## Verification
Every output is a register, or a combinational function of registers, updated by the edge that samples the stimulus. Each result is therefore due exactly one cycle after si_i is sampled, and every edge of a frame moves all outputs by one step. The bench drives si_i and samples every output 1 ns after each rising edge. It compares them with the frame position, which it computes from the edge count. Intrusive start pulses are placed at the second and last busy edges and in mid-frame. A restart is placed at the earliest legal edge.

// File: rtl/lsps_pkg.sv
package lsps_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_RESET = 2'd1,
      PH_INTEG = 2'd2
   } phase_e;

   localparam int unsigned ENC_MASK = 0;
   localparam int unsigned ENC_SCAN = 1;
endpackage

// File: rtl/lsps_select_chain.sv
module lsps_select_chain #(
   parameter int unsigned NUM_PIX = 128
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               start_i,
   output logic [NUM_PIX-1:0] sel_o
);
   logic [NUM_PIX-1:0] stage_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) stage_q[0] <= 1'b0;
      else       stage_q[0] <= start_i;
   end

   for (genvar i = 1; i < NUM_PIX; i++) begin : g_stage
      always_ff @(posedge clk_i) begin
         if (rst_i) stage_q[i] <= 1'b0;
         else       stage_q[i] <= stage_q[i-1];
      end

      // R3
      token_moves_chk: assert property (@(posedge clk_i) disable iff (rst_i)
         stage_q[i-1] |=> stage_q[i]);
   end

   assign sel_o = stage_q;
endmodule

// File: rtl/lsps_frame_timer.sv
module lsps_frame_timer
   import lsps_pkg::*;
#(
   parameter int unsigned NUM_PIX  = 128,
   parameter int unsigned RST_CLKS = 18
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic si_i,
   output logic start_o,
   output logic busy_o,
   output logic hold_o,
   output logic int_rst_o,
   output logic err_o
);
   localparam int unsigned CNT_W = $clog2(NUM_PIX + 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_PIX);
   localparam logic [CNT_W-1:0] RST_END  = CNT_W'(RST_CLKS);

   logic [CNT_W-1:0] cnt_q;
   phase_e           ph_q;
   logic             hold_q;
   logic             err_q;
   logic             busy;
   logic             start;

   assign busy  = (cnt_q != '0);
   assign start = si_i & ~busy;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q  <= '0;
         ph_q   <= PH_IDLE;
         hold_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         hold_q <= start;
         if (si_i && busy) err_q <= 1'b1;
         if (start) begin
            cnt_q <= CNT_W'(1);
            ph_q  <= PH_RESET;
         end else if (busy) begin
            if (cnt_q == LAST_CNT) begin
               cnt_q <= '0;
               ph_q  <= PH_IDLE;
            end else begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == RST_END) ph_q <= PH_INTEG;
            end
         end
      end
   end

   assign start_o   = start;
   assign busy_o    = busy;
   assign hold_o    = hold_q;
   assign int_rst_o = (ph_q == PH_RESET);
   assign err_o     = err_q;

   // R9
   err_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      err_q |=> err_q);

   // R8
   busy_start_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (busy && si_i) |=> (err_q && cnt_q != CNT_W'(1)));

   // R5
   rst_window_end_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      ($fell(ph_q == PH_RESET) && !$past(rst_i)) |-> (cnt_q == RST_END + 1'b1));
endmodule

// File: rtl/lsps_index_enc.sv
module lsps_index_enc
   import lsps_pkg::*;
#(
   parameter int unsigned NUM_PIX   = 128,
   parameter int unsigned ENC_STYLE = ENC_MASK,
   localparam int unsigned IDX_W    = $clog2(NUM_PIX)
) (
   input  logic [NUM_PIX-1:0] sel_i,
   output logic [IDX_W-1:0]   idx_o,
   output logic               vld_o
);
   if (ENC_STYLE == ENC_MASK) begin : g_mask
      for (genvar b = 0; b < IDX_W; b++) begin : g_bit
         always_comb begin
            logic acc;
            acc = 1'b0;
            for (int i = 0; i < NUM_PIX; i++) begin
               if (((i >> b) & 1) == 1) acc = acc | sel_i[i];
            end
            idx_o[b] = acc;
         end
      end
   end else begin : g_scan
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < NUM_PIX; i++) begin
            if (sel_i[i]) idx_o = IDX_W'(i);
         end
      end
   end

   assign vld_o = |sel_i;
endmodule

// File: rtl/linsens_seq.sv
module linsens_seq
   import lsps_pkg::*;
#(
   parameter int unsigned NUM_PIX   = 128,
   parameter int unsigned RST_CLKS  = 18,
   parameter int unsigned ENC_STYLE = ENC_MASK,
   localparam int unsigned IDX_W    = $clog2(NUM_PIX)
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               si_i,
   output logic [NUM_PIX-1:0] pix_sel_o,
   output logic [IDX_W-1:0]   pix_idx_o,
   output logic               pix_vld_o,
   output logic               hold_o,
   output logic               int_rst_o,
   output logic               out_en_o,
   output logic               proto_err_o
);
   if (NUM_PIX < 2) begin : g_bad_pix
      $error("NUM_PIX must be at least 2");
   end
   if (RST_CLKS < 1 || RST_CLKS >= NUM_PIX) begin : g_bad_rst
      $error("RST_CLKS must lie in 1 .. NUM_PIX-1");
   end
   if (ENC_STYLE != ENC_MASK && ENC_STYLE != ENC_SCAN) begin : g_bad_enc
      $error("ENC_STYLE must be ENC_MASK or ENC_SCAN");
   end

   logic start;
   logic busy;

   lsps_frame_timer #(
      .NUM_PIX  (NUM_PIX),
      .RST_CLKS (RST_CLKS)
   ) u_timer (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .si_i      (si_i),
      .start_o   (start),
      .busy_o    (busy),
      .hold_o    (hold_o),
      .int_rst_o (int_rst_o),
      .err_o     (proto_err_o)
   );

   lsps_select_chain #(
      .NUM_PIX (NUM_PIX)
   ) u_chain (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .start_i (start),
      .sel_o   (pix_sel_o)
   );

   lsps_index_enc #(
      .NUM_PIX   (NUM_PIX),
      .ENC_STYLE (ENC_STYLE)
   ) u_enc (
      .sel_i (pix_sel_o),
      .idx_o (pix_idx_o),
      .vld_o (pix_vld_o)
   );

   assign out_en_o = busy;

   // R3
   sel_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(pix_sel_o));

   // R4
   hold_first_pix_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      hold_o |-> pix_sel_o[0]);

   // R6
   out_en_match_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      out_en_o == (|pix_sel_o));

   // R6
   release_after_last_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      pix_sel_o[NUM_PIX-1] |=> !out_en_o);

   // R10
   idx_points_sel_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      pix_vld_o |-> pix_sel_o[pix_idx_o]);
endmodule

// File: tb/linsens_seq_bench.sv
`timescale 1ns/1ps
module linsens_seq_bench;
   localparam int N  = 128;
   localparam int RC = 18;
   localparam int IW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          si  = 1'b0;
   logic [N-1:0]  sel;
   logic [IW-1:0] idx;
   logic          vld, hold, irst, oen, perr;

   int checks = 0;
   int errors = 0;
   int k      = 0;
   logic err_m  = 1'b0;
   logic hold_m = 1'b0;
   bit done = 0;

   always #2.5 clk = ~clk;

   linsens_seq u_linsens_seq (
      .clk_i(clk), .rst_i(rst), .si_i(si),
      .pix_sel_o(sel), .pix_idx_o(idx), .pix_vld_o(vld),
      .hold_o(hold), .int_rst_o(irst), .out_en_o(oen), .proto_err_o(perr)
   );

   task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s k=%0d actual=%h expected=%h", tag, k, act, exp);
      end
   endtask

   task automatic check_all();
      logic [N-1:0] sel_e;
      sel_e = (k == 0) ? '0 : (N'(1) << (k - 1));
      chk("R3 sel", sel, sel_e);
      chk("R10 idx", N'(idx), (k == 0) ? '0 : N'(k - 1));
      chk("R10 vld", N'(vld), N'(k != 0));
      chk("R4 hold", N'(hold), N'(hold_m));
      chk("R5 int_rst", N'(irst), N'(k >= 1 && k <= RC));
      chk("R6 out_en", N'(oen), N'(k != 0));
      chk("R8 err", N'(perr), N'(err_m));
   endtask

   task automatic tick(input logic s);
      logic st;
      si = s;
      @(posedge clk);
      #1;
      si = 1'b0;
      st = s && (k == 0);
      if (s && k != 0) err_m = 1'b1;
      if (st) k = 1;
      else if (k != 0) k = (k == N) ? 0 : k + 1;
      hold_m = st;
      check_all();
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(posedge clk);
      #1;
      rst = 1'b0;
      k = 0; err_m = 1'b0; hold_m = 1'b0;
      check_all();
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: idle after reset
      do_reset();
      chk("R1 sel", sel, '0);
      chk("R1 flags", N'({hold, irst, oen, vld, perr}), '0);
      repeat (3) tick(1'b0);

      // R2: first frame start
      tick(1'b1);
      chk("R2 pixel1", sel, N'(1));
      for (int i = 0; i < N; i++) tick(1'b0);
      // R6: released after edge N+1
      chk("R6 released", N'({oen, |sel}), '0);

      // R7: restart at edge N+2
      tick(1'b1);
      chk("R7 restart", sel, N'(1));
      chk("R7 hold", N'(hold), N'(1));
      // R8: intrusions at edge 2, mid-frame and edge N+1
      while (k != 0) tick(k == 1 || k == 50 || k == N);
      chk("R8 flag set", N'(perr), N'(1));
      repeat (5) tick(1'b0);
      // R9: sticky through idle
      chk("R9 sticky", N'(perr), N'(1));
      do_reset();
      chk("R9 cleared", N'(perr), '0);

      // sweep idle gaps before start
      for (int g = 0; g < 4; g++) begin
         repeat (g) tick(1'b0);
         tick(1'b1);
         while (k != 0) tick(1'b0);
      end
      chk("R9 no spurious", N'(perr), '0);

      // reset in mid-frame returns to idle
      tick(1'b1);
      repeat (30) tick(1'b0);
      do_reset();
      chk("R1 mid reset", sel, '0);
      tick(1'b0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule